// File: doc/BRIEF.md
# AHB-Lite Single-Transfer Manager with Error Abort

This block is a bus manager for an AHB-Lite fabric. It takes read and write commands from a valid/ready command stream and holds them in a small in-order queue. It issues each command as a single NONSEQ transfer. The block runs the pipelined address and data phases itself. It drives the address, direction and transfer type, and it drives the write data one phase later. It reports every completed transfer on a response stream, flagged as good or failed.

A subordinate signals an error in two cycles. The `abort_en` input selects how the manager reacts to this. With abort selected, the manager sees the first error cycle (ready low, response ERROR) and replaces the next transfer it was already presenting with IDLE. When the failing transfer ends, the manager stops issuing. It raises `err_flag` with the failing address and waits for `err_clear`. It then restarts from the command it cancelled, so no command is lost and program order is kept. Without abort, the pending transfer stays on the bus and the error costs only one added wait state. The flag is still raised.

Command stream rules: a command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` falls only when the queue is full, and it does not depend on `cmd_valid` in the same cycle. The response stream has no back-pressure. `rsp_valid` is high for exactly one cycle per completed transfer, and the consumer must take the response in that cycle.

Top module: `ahbm_err_mgr`

## Requirements
- R1: A command is stored when `cmd_valid` and `cmd_ready` are high at a clock edge. `cmd_ready` is low exactly while the queue holds QDEPTH commands. Commands go to the bus in the order they were accepted.
- R2: `htrans` uses IDLE = 2'b00 and NONSEQ = 2'b10 only. BUSY (2'b01) and SEQ (2'b11) never appear. NONSEQ is driven whenever a queued command may be issued, and IDLE is driven otherwise.
- R3: An address phase is taken only at an edge with `hready` high. While `hready` is low, a presented NONSEQ keeps `haddr` and `hwrite` stable or is replaced by IDLE.
- R4: Write data appears on `hwdata` in the data phase after the write's address phase, and it is held stable while `hready` is low. The written data is what later reads return.
- R5: Each completed transfer gives one `rsp_valid` pulse, in issue order. The pulse carries `rsp_write`, `rsp_err` (1 = ERROR) and, for a good read, the read data in `rsp_rdata`.
- R6: With `abort_en` = 1, the cycle after a cycle with `hready` low and `hresp` = 1 shows `htrans` = IDLE.
- R7: With `abort_en` = 0, a NONSEQ presented during the first error cycle stays NONSEQ with the same `haddr` in the second error cycle.
- R8: When a failed transfer completes, `err_flag` rises on the next cycle and `err_addr` gives that transfer's address. An `err_clear` pulse lowers the flag.
- R9: After an aborted error, `htrans` stays IDLE until `err_clear`, even with commands queued. Issuing then resumes from the cancelled command, which is not dropped.
- R10: Reset is synchronous and active low. After reset `htrans` is IDLE, the queue is empty (`cmd_ready` = 1), `err_flag` = 0 and `rsp_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Queue has room |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Command address |
| cmd_wdata | input | DATA_W | Write data of the command |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_write | output | 1 | Completed transfer was a write |
| rsp_err | output | 1 | Completed transfer got ERROR |
| rsp_rdata | output | DATA_W | Read data of the completed read |
| abort_en | input | 1 | 1 = cancel pending transfer on error |
| err_clear | input | 1 | Clears the error flag and resumes |
| err_flag | output | 1 | Sticky error indication |
| err_addr | output | ADDR_W | Address of the failed transfer |
| haddr | output | ADDR_W | Bus address |
| hwrite | output | 1 | Bus direction |
| htrans | output | 2 | Bus transfer type |
| hwdata | output | DATA_W | Bus write data |
| hready | input | 1 | Bus ready |
| hresp | input | 1 | Bus response, 1 = ERROR |
| hrdata | input | DATA_W | Bus read data |

## Verification
The bench uses a subordinate model that inserts 0 to 2 wait states per transfer and answers any address with bits [7:4] = 4'hE with a two-cycle ERROR. Plain write-then-read runs with varied stalls show whether write data is held and delivered correctly. An error on a write with more commands queued behind it separates abort from continue: in abort mode the second error cycle must show IDLE and the cancelled command must complete after the clear, and in continue mode the next address must stay unchanged. An error on a read checks that failed reads are reported and not mixed up with good data. Filling the queue while the manager is halted checks the full condition and shows that nothing leaks onto the bus before the clear.

// File: rtl/ahbm_pkg.sv
package ahbm_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } htrans_e;
endpackage

// File: rtl/ahbm_cmd_fifo.sv
module ahbm_cmd_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [PW-1:0]    rd_ptr, wr_ptr;
  logic [CW-1:0]    fill;
  logic             do_push, do_pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (fill == '0);
  assign full    = (fill == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) slots[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      fill <= fill + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/ahbm_dphase.sv
module ahbm_dphase #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hready,
  input  logic              hresp,
  input  logic [DATA_W-1:0] hrdata,
  input  logic              issue,
  input  logic              a_write,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [ADDR_W-1:0] dp_addr,
  output logic [DATA_W-1:0] hwdata,
  output logic              rsp_valid,
  output logic              rsp_write,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              err_first,
  output logic              err_done
);
  logic              dp_valid;
  logic              dp_write;
  logic [DATA_W-1:0] dp_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dp_valid <= 1'b0;
      dp_write <= 1'b0;
      dp_addr  <= '0;
      dp_wdata <= '0;
    end else if (hready) begin
      dp_valid <= issue;
      dp_write <= a_write;
      dp_addr  <= a_addr;
      dp_wdata <= a_wdata;
    end
  end

  assign hwdata    = dp_wdata;
  assign rsp_valid = dp_valid && hready;
  assign rsp_write = dp_write;
  assign rsp_err   = hresp;
  assign rsp_rdata = hrdata;
  assign err_first = dp_valid && !hready && hresp;
  assign err_done  = dp_valid && hready && hresp;
endmodule

// File: rtl/ahbm_err_ctl.sv
module ahbm_err_ctl #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hready,
  input  logic              abort_en,
  input  logic              err_first,
  input  logic              err_done,
  input  logic [ADDR_W-1:0] dp_addr,
  input  logic              err_clear,
  output logic              cancel,
  output logic              halt,
  output logic              err_flag,
  output logic [ADDR_W-1:0] err_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n)                      cancel <= 1'b0;
    else if (hready)                 cancel <= 1'b0;
    else if (err_first && abort_en)  cancel <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  halt <= 1'b0;
    else if (err_done && cancel) halt <= 1'b1;
    else if (err_clear)          halt <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_flag <= 1'b0;
      err_addr <= '0;
    end else if (err_done) begin
      err_flag <= 1'b1;
      err_addr <= dp_addr;
    end else if (err_clear) begin
      err_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/ahbm_err_mgr.sv
module ahbm_err_mgr
  import ahbm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int QDEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  output logic              rsp_write,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              abort_en,
  input  logic              err_clear,
  output logic              err_flag,
  output logic [ADDR_W-1:0] err_addr,
  output logic [ADDR_W-1:0] haddr,
  output logic              hwrite,
  output logic [1:0]        htrans,
  output logic [DATA_W-1:0] hwdata,
  input  logic              hready,
  input  logic              hresp,
  input  logic [DATA_W-1:0] hrdata
);
  localparam int CMD_W = 1 + ADDR_W + DATA_W;

  logic [CMD_W-1:0]  q_din, q_head;
  logic              q_empty, q_full;
  logic              hd_write;
  logic [ADDR_W-1:0] hd_addr;
  logic [DATA_W-1:0] hd_wdata;
  logic              issue, pop;
  logic              halt, cancel;
  logic              err_first, err_done;
  logic [ADDR_W-1:0] dp_addr;

  assign q_din = {cmd_write, cmd_addr, cmd_wdata};

  ahbm_cmd_fifo #(.WIDTH(CMD_W), .DEPTH(QDEPTH)) u_queue (
    .clk  (clk),
    .rst_n(rst_n),
    .push (cmd_valid),
    .din  (q_din),
    .pop  (pop),
    .dout (q_head),
    .empty(q_empty),
    .full (q_full)
  );

  assign cmd_ready = !q_full;
  assign {hd_write, hd_addr, hd_wdata} = q_head;

  assign issue  = !q_empty && !halt && !cancel;
  assign pop    = issue && hready;
  assign htrans = issue ? TR_NONSEQ : TR_IDLE;
  assign haddr  = hd_addr;
  assign hwrite = hd_write;

  ahbm_dphase #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dphase (
    .clk      (clk),
    .rst_n    (rst_n),
    .hready   (hready),
    .hresp    (hresp),
    .hrdata   (hrdata),
    .issue    (issue),
    .a_write  (hd_write),
    .a_addr   (hd_addr),
    .a_wdata  (hd_wdata),
    .dp_addr  (dp_addr),
    .hwdata   (hwdata),
    .rsp_valid(rsp_valid),
    .rsp_write(rsp_write),
    .rsp_err  (rsp_err),
    .rsp_rdata(rsp_rdata),
    .err_first(err_first),
    .err_done (err_done)
  );

  ahbm_err_ctl #(.ADDR_W(ADDR_W)) u_errctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .hready   (hready),
    .abort_en (abort_en),
    .err_first(err_first),
    .err_done (err_done),
    .dp_addr  (dp_addr),
    .err_clear(err_clear),
    .cancel   (cancel),
    .halt     (halt),
    .err_flag (err_flag),
    .err_addr (err_addr)
  );
endmodule

// File: rtl/ahbm_err_mgr_chk.sv
module ahbm_err_mgr_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              abort_en,
  input logic              halt,
  input logic              err_flag,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [ADDR_W-1:0] haddr,
  input logic              hwrite,
  input logic [1:0]        htrans,
  input logic [DATA_W-1:0] hwdata,
  input logic              hready,
  input logic              hresp
);
  AST_TRANS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    htrans[0] == 1'b0); // R2

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b10 && !hready) |=> (htrans == 2'b00 || ($stable(haddr) && $stable(hwrite)))); // R3

  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hready |=> $stable(hwdata)); // R4

  AST_RSP_ON_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> hready); // R5

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hready && hresp && abort_en) |=> htrans == 2'b00); // R6

  AST_CONT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!hready && hresp && !abort_en && htrans == 2'b10) |=> (htrans == 2'b10 && $stable(haddr))); // R7

  AST_FLAG_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |=> err_flag); // R8

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (htrans == 2'b00 || !halt || $past(!halt))); // R9
endmodule

bind ahbm_err_mgr ahbm_err_mgr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .abort_en (abort_en),
  .halt     (halt),
  .err_flag (err_flag),
  .rsp_valid(rsp_valid),
  .rsp_err  (rsp_err),
  .haddr    (haddr),
  .hwrite   (hwrite),
  .htrans   (htrans),
  .hwdata   (hwdata),
  .hready   (hready),
  .hresp    (hresp)
);

// File: tb/ahbm_err_mgr_bench.sv
module ahbm_err_mgr_bench;
  localparam int QD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [31:0] cmd_addr = '0, cmd_wdata = '0;
  logic        cmd_ready;
  logic        rsp_valid, rsp_write, rsp_err;
  logic [31:0] rsp_rdata;
  logic        abort_en = 1'b1, err_clear = 1'b0;
  logic        err_flag;
  logic [31:0] err_addr, haddr, hwdata, hrdata;
  logic        hwrite, hready, hresp;
  logic [1:0]  htrans;

  always #2 clk = ~clk;

  ahbm_err_mgr #(.ADDR_W(32), .DATA_W(32), .QDEPTH(QD)) u_ahbm_err_mgr (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .abort_en(abort_en), .err_clear(err_clear), .err_flag(err_flag), .err_addr(err_addr),
    .haddr(haddr), .hwrite(hwrite), .htrans(htrans), .hwdata(hwdata),
    .hready(hready), .hresp(hresp), .hrdata(hrdata)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- subordinate model ----------------
  logic        s_act, s_write, s_err, s_ph2;
  logic [31:0] s_addr;
  logic [1:0]  s_ws;
  logic [7:0]  lfsr;
  logic [31:0] smem [16];

  assign hready = !s_act ? 1'b1 : (s_err ? s_ph2 : (s_ws == 2'd0));
  assign hresp  = s_act && s_err && (s_ws == 2'd0);
  assign hrdata = (s_act && !s_write) ? smem[s_addr[5:2]] : 32'h0;

  always @(posedge clk) begin
    if (!rst_n) begin
      s_act <= 0; s_write <= 0; s_err <= 0; s_ph2 <= 0; s_addr <= 0; s_ws <= 0;
      lfsr <= 8'h5A;
      for (int i = 0; i < 16; i++) smem[i] <= 32'h1000_0000 + i;
    end else if (hready) begin
      if (s_act && s_write && !s_err) smem[s_addr[5:2]] <= hwdata;
      s_act   <= (htrans == 2'b10);
      s_write <= hwrite;
      s_addr  <= haddr;
      s_err   <= (haddr[7:4] == 4'hE);
      s_ws    <= (lfsr[1:0] == 2'd3) ? 2'd0 : lfsr[1:0];
      s_ph2   <= 0;
      if (htrans == 2'b10) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end else begin
      if (s_ws != 0) s_ws <= s_ws - 1'b1;
      else if (s_err) s_ph2 <= 1'b1;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct packed { logic w; logic e; logic [31:0] d; } exp_t;
  exp_t        exp_q[$];
  logic [31:0] model [16];
  logic [31:0] exp_err_addr = '0;
  bit          hold_clear = 0;

  function automatic void expect_cmd(input bit w, input logic [31:0] a, input logic [31:0] d);
    exp_t x;
    x.w = w;
    x.e = (a[7:4] == 4'hE);
    if (w && !x.e) model[a[5:2]] = d;
    x.d = model[a[5:2]];
    exp_q.push_back(x);
    if (x.e) exp_err_addr = a;
  endfunction

  task automatic push_cmd(input bit w, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_write = w; cmd_addr = a; cmd_wdata = d;
    expect_cmd(w, a, d);
    @(posedge clk);
    #1 cmd_valid = 0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (exp_q.size() != 0 || err_flag) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor: completions in order (R5), also data path (R4)
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk(0, "R5 unexpected response", 1, 0);
      else begin
        exp_t x;
        x = exp_q.pop_front();
        chk(rsp_write == x.w, "R5 rsp_write", rsp_write, x.w);
        chk(rsp_err == x.e, "R5 rsp_err", rsp_err, x.e);
        if (!x.w && !x.e) chk(rsp_rdata == x.d, "R4 read data", rsp_rdata, x.d);
      end
    end
  end

  // encoding and error-window watcher (R2, R6, R7)
  bit          pend = 0, rec_abort = 0;
  logic [1:0]  rec_tr;
  logic [31:0] rec_addr;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(htrans == 2'b00 || htrans == 2'b10, "R2 htrans encoding", htrans, 2'b10);
      if (pend) begin
        if (rec_abort) chk(htrans == 2'b00, "R6 abort idle", htrans, 2'b00);
        else if (rec_tr == 2'b10) begin
          chk(htrans == 2'b10, "R7 keep nonseq", htrans, 2'b10);
          chk(haddr == rec_addr, "R7 keep addr", haddr, rec_addr);
        end
        pend = 0;
      end
      if (!hready && hresp) begin
        pend = 1; rec_tr = htrans; rec_addr = haddr; rec_abort = abort_en;
      end
    end
  end

  // error handler (R8, R9)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && err_flag && !hold_clear) begin
        chk(err_addr == exp_err_addr, "R8 err_addr", err_addr, exp_err_addr);
        if (abort_en) begin
          for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(htrans == 2'b00, "R9 halted idle", htrans, 2'b00);
          end
        end
        err_clear = 1;
        @(negedge clk);
        err_clear = 0;
        chk(err_flag == 1'b0, "R8 flag cleared", err_flag, 0);
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  // main sequence
  initial begin
    int acc;
    for (int i = 0; i < 16; i++) model[i] = 32'h1000_0000 + i;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(htrans == 2'b00, "R10 reset htrans", htrans, 0);
    chk(cmd_ready == 1'b1, "R10 reset queue empty", cmd_ready, 1);
    chk(err_flag == 1'b0, "R10 reset err_flag", err_flag, 0);
    chk(rsp_valid == 1'b0, "R10 reset rsp_valid", rsp_valid, 0);

    // plain traffic, varied wait states (R1 R3 R4 R5)
    abort_en = 1;
    for (int i = 0; i < 4; i++) push_cmd(1, 32'(i * 4), 32'hA000_0000 + i);
    for (int i = 0; i < 4; i++) push_cmd(0, 32'(i * 4), 0);
    drain();

    // write error with followers, abort mode (R6 R8 R9)
    push_cmd(1, 32'h10, 32'hB0B0_0010);
    push_cmd(1, 32'hE4, 32'hDEAD_0001);
    push_cmd(0, 32'h10, 0);
    push_cmd(1, 32'h14, 32'hB0B0_0014);
    push_cmd(0, 32'h14, 0);
    drain();

    // read error, abort mode
    push_cmd(0, 32'hE8, 0);
    push_cmd(0, 32'h04, 0);
    push_cmd(0, 32'h00, 0);
    drain();

    // continue mode (R7 R8)
    abort_en = 0;
    push_cmd(1, 32'hEC, 32'hDEAD_0002);
    push_cmd(1, 32'h18, 32'hC0C0_0018);
    push_cmd(0, 32'h18, 0);
    drain();

    // fill the queue while halted (R1 R9)
    abort_en = 1;
    hold_clear = 1;
    push_cmd(1, 32'hE0, 32'hDEAD_0003);
    @(negedge clk);
    while (!err_flag) @(negedge clk);
    acc = 0;
    for (int i = 0; i < QD + 2; i++) begin
      @(negedge clk);
      chk(htrans == 2'b00, "R9 idle while halted", htrans, 0);
      if (cmd_ready) begin
        cmd_valid = 1; cmd_write = (i % 2 == 0); cmd_addr = 32'h20 + 32'(4 * (i / 2));
        cmd_wdata = 32'hF00D_0000 + i;
        expect_cmd(cmd_write, cmd_addr, cmd_wdata);
        acc++;
        @(posedge clk);
        #1 cmd_valid = 0;
      end
    end
    @(negedge clk);
    chk(cmd_ready == 1'b0, "R1 full ready low", cmd_ready, 0);
    chk(acc == QD, "R1 accepted count", acc, QD);
    hold_clear = 0;
    drain();

    chk(exp_q.size() == 0, "R5 all completed", exp_q.size(), 0);
    chk(cmd_ready == 1'b1, "R1 ready after drain", cmd_ready, 1);
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule